// File: doc/BRIEF.md
# First-Hit Reset and Expiry Tracker

This block sits beside one per-crossing hit buffer and governs its lifetime. The buffer is never cleared when it is read. Instead, the first hit that arrives for a new bunch crossing clears it lazily. At that moment the tracker issues a reset pulse of fixed length to the buffer and holds off the write path until the pulse ends. It also raises two flags. The short-lived `cur_flag` marks the buffer as belonging to the crossing now being written. The longer-lived `valid_flag` marks its contents as still fit to be read out.

Each flag has its own ageing counter. The write-side counter counts clock cycles. The read-side counter counts crossing ticks and by default runs for 64 crossings. When a counter reaches its limit, its flag drops. Once `valid_flag` has dropped, the buffered hits count as expired, and a read request is refused.

A write is treated as the first hit of a new crossing in two cases:
- it arrives while `cur_flag` is low, or
- the crossing-compare strobe says the hit belongs to a different crossing than the one the buffer holds.

Later hits of the same crossing pass straight through to the buffer.

Top module: `hit_age_tracker`

## Requirements
- R1: After reset, every output (`fifo_rst`, `wr_stall`, `fifo_we`, `cur_flag`, `valid_flag`, `rd_grant`) is low.
- R2: A cycle counts as a first hit when all three hold: `wr_en` is high, no reset pulse is active, and either `cur_flag` is low or `bco_cmp` is high. In that cycle `wr_stall` is high and `fifo_we` is low.
- R3: `fifo_rst` is high for exactly RST_CYCLES consecutive cycles, starting in the cycle after a first hit.
- R4: While `fifo_rst` is high, `wr_stall` is high and `fifo_we` is low. During that time `wr_en` and `bco_cmp` neither lengthen the pulse nor restart the flags.
- R5: In the cycle after a first hit, both `cur_flag` and `valid_flag` are high.
- R6: `cur_flag` stays high for exactly SHORT_LIMIT cycles after a first hit and then drops, unless another first hit restarts it.
- R7: `valid_flag` drops after LONG_LIMIT `xing_tick` pulses have been sampled in the cycles after the first hit. Clock cycles without a tick do not age it.
- R8: When `wr_en` is high, `cur_flag` is high, `bco_cmp` is low and no pulse is active, the write passes: `fifo_we` is high, `wr_stall` is low, and neither counter restarts.
- R9: When `wr_en` and `bco_cmp` are both high while `cur_flag` is high and no pulse is active, the cycle is a new first hit. It issues a fresh reset pulse and restarts both counters.
- R10: `rd_grant` equals `rd_req` while `valid_flag` is high and is low while `valid_flag` is low, so expired contents are never granted.
- R11: `bco_cmp` or `xing_tick` without `wr_en` never starts a reset pulse or raises a flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | A hit is offered to the buffer this cycle |
| bco_cmp | input | 1 | The offered hit belongs to a different crossing than the buffered one |
| xing_tick | input | 1 | One-cycle pulse per bunch crossing, ages the read-side flag |
| rd_req | input | 1 | Readout asks for this buffer's contents |
| fifo_rst | output | 1 | Reset pulse to the hit buffer |
| wr_stall | output | 1 | Offered hit is not accepted this cycle and must be held |
| fifo_we | output | 1 | Write strobe to the hit buffer |
| cur_flag | output | 1 | Buffer belongs to the crossing now being written |
| valid_flag | output | 1 | Buffer contents are not yet expired |
| rd_grant | output | 1 | Read request honoured |

## Verification
The hardest cases to reach are the collisions between the three timers. Examples are a crossing-compare strobe that lands inside the reset pulse, a write that arrives on the exact cycle `cur_flag` falls, and a read that arrives on the exact cycle the last crossing tick retires `valid_flag`. Directed sequences place a hit, hold `wr_en` through the pulse, and then step the cycle and tick counts to land on each of these edges. A long pseudo-random phase then mixes writes, strobes, ticks and reads at varied densities. Throughout, a cycle model built from the requirements predicts every output.

// File: rtl/hit_age_pkg.sv
package hit_age_pkg;

  // Counter width able to hold values 0..n-1, at least one bit.
  function automatic int unsigned cnt_w(input int unsigned n);
    if (n <= 2) return 1;
    return $clog2(n);
  endfunction

  typedef struct packed {
    logic cur;
    logic valid;
  } age_flags_t;

endpackage

// File: rtl/hit_age_rst_sync.sv
module hit_age_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_s = sync_q;
endmodule

// File: rtl/hit_age_pulser.sv
module hit_age_pulser #(
  parameter int unsigned RST_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = hit_age_pkg::cnt_w(RST_CYCLES + 1);

  logic [CW-1:0] left_q;
  logic [CW-1:0] left_d;
  logic          left_en;

  always_comb begin
    left_en = 1'b0;
    left_d  = left_q;
    if (start) begin
      left_en = 1'b1;
      left_d  = CW'(RST_CYCLES);
    end else if (left_q != '0) begin
      left_en = 1'b1;
      left_d  = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  assign busy = (left_q != '0);

  AST_PULSE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R3
  AST_PULSE_NO_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start |=> (left_q < $past(left_q))); // R4
endmodule

// File: rtl/hit_age_timer.sv
module hit_age_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic step,
  output logic active
);
  localparam int unsigned CW = hit_age_pkg::cnt_w(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          upd;

  always_comb begin
    upd   = 1'b0;
    cnt_d = cnt_q;
    act_d = act_q;
    if (start) begin
      upd   = 1'b1;
      cnt_d = '0;
      act_d = 1'b1;
    end else if (act_q && step) begin
      upd = 1'b1;
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;

  AST_TIMER_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q && !start |=> !act_q); // R11
  AST_TIMER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !step && !start |=> act_q && $stable(cnt_q)); // R7
endmodule

// File: rtl/hit_age_tracker.sv
module hit_age_tracker #(
  parameter int unsigned RST_CYCLES  = 3,
  parameter int unsigned SHORT_LIMIT = 16,
  parameter int unsigned LONG_LIMIT  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic bco_cmp,
  input  logic xing_tick,
  input  logic rd_req,
  output logic fifo_rst,
  output logic wr_stall,
  output logic fifo_we,
  output logic cur_flag,
  output logic valid_flag,
  output logic rd_grant
);
  import hit_age_pkg::*;

  logic       rst_n_s;
  logic       pulse_busy;
  logic       first_hit;
  age_flags_t flags;

  hit_age_rst_sync u_rsync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  // A new crossing is recognised only while no reset pulse is running.
  always_comb begin
    first_hit = wr_en && !pulse_busy && (!flags.cur || bco_cmp);
  end

  hit_age_pulser #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n_s),
    .start (first_hit),
    .busy  (pulse_busy)
  );

  hit_age_timer #(.LIMIT(SHORT_LIMIT)) u_short (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .start  (first_hit),
    .step   (1'b1),
    .active (flags.cur)
  );

  hit_age_timer #(.LIMIT(LONG_LIMIT)) u_long (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .start  (first_hit),
    .step   (xing_tick),
    .active (flags.valid)
  );

  always_comb begin
    fifo_rst   = pulse_busy;
    wr_stall   = pulse_busy || first_hit;
    fifo_we    = wr_en && !wr_stall;
    cur_flag   = flags.cur;
    valid_flag = flags.valid;
    rd_grant   = rd_req && flags.valid;
  end

  AST_FIRST_RAISES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n_s)
    first_hit |=> cur_flag && valid_flag); // R5
  AST_NO_WRITE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    fifo_rst |-> !fifo_we && wr_stall); // R4
  AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(fifo_rst) |-> $past(wr_en)); // R2
  AST_NO_STALE_GRANT: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_grant |-> valid_flag && rd_req); // R10
  AST_PASS_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n_s)
    fifo_we |=> !fifo_rst); // R8
endmodule

// File: tb/hit_age_tracker_test.sv
`timescale 1ns/1ps
module hit_age_tracker_test;
  localparam int RSTC = 3;
  localparam int SHL  = 16;
  localparam int LGL  = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, bco_cmp, xing_tick, rd_req;
  logic fifo_rst, wr_stall, fifo_we, cur_flag, valid_flag, rd_grant;

  always #2.5 clk = ~clk;

  hit_age_tracker #(.RST_CYCLES(RSTC), .SHORT_LIMIT(SHL), .LONG_LIMIT(LGL)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bco_cmp(bco_cmp),
    .xing_tick(xing_tick), .rd_req(rd_req), .fifo_rst(fifo_rst),
    .wr_stall(wr_stall), .fifo_we(fifo_we), .cur_flag(cur_flag),
    .valid_flag(valid_flag), .rd_grant(rd_grant)
  );

  typedef struct {
    logic [5:0] exp;   // {rst, stall, we, cur, valid, grant}
    string      tag;
  } item_t;

  item_t q[$];
  event  item_ev;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state: cycles or ticks still to run.
  int m_rst = 0, m_short = 0, m_long = 0;

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", what, act, exp, $time);
    end
  endtask

  // Monitor: pops expected items and compares against the ports.
  initial begin
    forever begin
      @(item_ev);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(fifo_rst,   it.exp[5], {"R3 fifo_rst ", it.tag});
        check(wr_stall,   it.exp[4], {"R4 wr_stall ", it.tag});
        check(fifo_we,    it.exp[3], {"R8 fifo_we ", it.tag});
        check(cur_flag,   it.exp[2], {"R6 cur_flag ", it.tag});
        check(valid_flag, it.exp[1], {"R7 valid_flag ", it.tag});
        check(rd_grant,   it.exp[0], {"R10 rd_grant ", it.tag});
      end
    end
  end

  // Driver: one cycle of stimulus, push expectation, advance the model.
  task automatic cyc(input logic w, input logic b, input logic t, input logic r,
                     input string tag);
    item_t it;
    logic first, stall;
    @(negedge clk);
    wr_en = w; bco_cmp = b; xing_tick = t; rd_req = r;
    #1;
    first = w && (m_rst == 0) && ((m_short == 0) || b);
    stall = (m_rst != 0) || first;
    it.exp = {m_rst != 0, stall, w && !stall, m_short != 0, m_long != 0,
              r && (m_long != 0)};
    it.tag = tag;
    q.push_back(it);
    ->item_ev;
    @(posedge clk);
    if (first) begin
      m_rst = RSTC; m_short = SHL; m_long = LGL;
    end else begin
      if (m_rst > 0) m_rst--;
      if (m_short > 0) m_short--;
      if (m_long > 0 && t) m_long--;
    end
  endtask

  task automatic idle(input int n, input logic t, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, t, 1'b1, tag);
  endtask

  initial begin
    wr_en = 0; bco_cmp = 0; xing_tick = 0; rd_req = 0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(fifo_rst, 1'b0, "R1 fifo_rst");
    check(wr_stall, 1'b0, "R1 wr_stall");
    check(fifo_we, 1'b0, "R1 fifo_we");
    check(cur_flag, 1'b0, "R1 cur_flag");
    check(valid_flag, 1'b0, "R1 valid_flag");
    check(rd_grant, 1'b0, "R1 rd_grant");

    // R11: strobes and ticks without writes start nothing
    cyc(0, 1, 1, 1, "R11 bco only");
    cyc(0, 1, 0, 0, "R11 bco only");
    idle(3, 1, "R11 ticks only");
    // R10: read while expired is refused
    cyc(0, 0, 0, 1, "R10 read expired");

    // R2/R3/R4/R5: first hit, wr_en held through the pulse
    cyc(1, 0, 0, 0, "R2 first hit");
    cyc(1, 1, 0, 1, "R4 bco in pulse");
    cyc(1, 0, 1, 1, "R5 flags up");
    cyc(1, 1, 0, 0, "R4 bco in pulse");
    // R8: later hits pass
    for (int i = 0; i < 5; i++) cyc(1, 0, i[0], 1, "R8 pass");
    // R9: compare strobe with write restarts
    cyc(1, 1, 0, 1, "R9 restart");
    idle(RSTC, 0, "R9 pulse");
    // R6: let cur_flag age out, write lands on the falling edge
    idle(SHL - RSTC - 1, 0, "R6 ageing");
    cyc(1, 0, 0, 1, "R6 last cycle");
    cyc(1, 0, 0, 1, "R6 expired write");
    idle(RSTC + SHL + 2, 0, "R6 age out again");
    // R7: valid ages only by ticks
    for (int i = 0; i < LGL + 4; i++) begin
      cyc(0, 0, 1'b0, 1, "R7 no tick");
      cyc(0, 0, 1'b1, 1, "R7 tick");
    end
    cyc(0, 0, 0, 1, "R10 read after expiry");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom;
      cyc(r[2:0] < 3, r[6:3] == 0, r[8:7] == 0, r[9], "mix");
    end
    idle(4, 0, "tail");
    finished = 1;
    #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule